// File: doc/BRIEF.md
# Link-Rate PHY Configuration Sequencer

This block turns a requested link rate into the ordered list of register writes that brings up a serial-link PLL and its two transmit lane pairs. A pulse on `start` captures the request together with a packed spare configuration byte (lane count and connector orientation), a bonding flag and a spread-spectrum flag. The block then plays the writes out one at a time on a simple write-master port. Each write is held on the port until the target accepts it with `wr_ready`.

The rate input gives the link clock in MHz. The block scales it by ten and snaps it upward to one of four line rates: 1.62, 2.7, 5.4 or 8.1 Gb/s. That bucket selects a parameter set, and this set fills the rate-dependent writes. The other inputs steer the power-down, mode, bias and spread-spectrum writes. When the final divider write is accepted, `done` rises and stays high. A request of zero sets `err` and issues no writes.

Top module: `link_rate_phy_seq`

## Requirements
- R1: `rate_req` (MHz of link clock) times ten selects the bucket. A value ≤1620 gives 1.62G. A value ≤2700 gives 2.7G. A value ≤5400 gives 5.4G. Anything larger gives 8.1G. The bucket is visible as the data of the write to address 0x10: 0x05, 0x03, 0x01 and 0x00 respectively.
- R2: A `start` with `rate_req` of zero sets `err`, keeps `done` low and issues no write. The next accepted request clears `err`.
- R3: Rate sets, listed per bucket 1.62/2.7/5.4/8.1:
  - 0x11 gets 69/69/8c/69.
  - 0x13 gets 80/80/00/80.
  - 0x14 gets 07/07/0a/07.
  - 0x15 gets 6f/0f/1f/2f.
  - 0x16 gets 08/0e/1c/2a.
  - 0x17 gets 04/08/08/08.
  - 0x08 (first write) gets 01/01/02/00.
  - 0x21 gets E2/E2/2E/E2.
  - 0x22 gets 18/18/21/18.
  - 0x32 gets 36/40/40/40.
  - 0x34 gets 45/13/1a/13.
  - 0x35 gets 06/06/08/06.
  - 0x12 always gets 0x00.
- R4: The power-down write (0x06) depends on lane count and orientation. It is 0x7d for four lanes. Otherwise it is 0x6d when flipped and 0x75 when normal.
- R5: The six spread-spectrum writes go to 0x30–0x35 and appear only when `ssc_en` is set. Address 0x30 gets 0x01, 0x31 gets 0x00 and 0x33 gets 0x01.
- R6: The mode write (0x07) is 0x4c when flipped and 0x5c when normal.
- R7: The bias write (0x20) is 0x1f with bonding and 0x1D without.
- R8: In `spare_cfg`, bits [3:0] are the lane count and bits [7:4] the orientation. Orientation code 2 means flipped, and every other code means normal.
- R9: The last write goes to 0x08 and carries the divider code. This is 0 at 8.1G, 2 at 5.4G and 1 at the other rates.
- R10: The write order is fixed:
  - 0x04←0x0F, 0x06, 0x10, 0x11, 0x12, 0x13, 0x14, 0x15, 0x16, 0x17, 0x08, 0x20, 0x21, 0x22.
  - The spread-spectrum group, if enabled.
  - 0x07, 0x0A←0x13, 0x0B←0xA4.
  - A three-write group for lane pair p: 0x0C+p←0x05, 0x40+16p←0x04, 0x41+16p←0x0F. Pair 0 comes first, then pair 1.
  - The final write to 0x08.
- R11: `wr_valid` is high exactly while `busy`. Address and data stay stable until `wr_ready` is sampled high. Each accepted transfer advances by one write.
- R12: Inputs are sampled only at the accepted `start`. Changes to them, and further `start` pulses, have no effect while `busy`.
- R13: After reset, `busy`, `done`, `err` and `wr_valid` are low. `done` rises the cycle after the last write is accepted and holds until the next `start`. On an accepted request, `busy` is high and `done` low from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse |
| rate_req | input | RATE_W | Requested link clock in MHz |
| spare_cfg | input | 8 | Lane count [3:0], orientation [7:4] |
| bonding_en | input | 1 | Bonded PLL operation |
| ssc_en | input | 1 | Spread spectrum enable |
| wr_addr | output | 8 | Write address |
| wr_data | output | 8 | Write data |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Write accepted |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence completed |
| err | output | 1 | Unsupported (zero) rate |

## Verification
The bench aims at the bucket edges: 162 versus 163 MHz, 270, 540 versus 541, 1 MHz and the maximum input. A comparison that is strict instead of inclusive would show a wrong high-speed select and rate set. It also runs each combination of lane count and orientation, each bonding setting and both spread-spectrum settings. A wrong branch shows up as a bad data byte, and a missed skip shows up as extra or missing writes at 0x30–0x35. Stalling ready patterns would expose a sequencer that advances without a handshake, because writes would be dropped or duplicated. A disturbance mid-run, made of new inputs and a second start, shows whether the sampled configuration leaks into a live sequence. A zero request must produce an error with an empty write stream.

// File: rtl/lrps_pkg.sv
package lrps_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 8;
  localparam int THR_LO = 1620;
  localparam int THR_MID = 2700;
  localparam int THR_HI = 5400;

  // fixed step positions; lane groups and the final step follow S_LANE0
  localparam int S_CFG1 = 0;
  localparam int S_PWDN = 1;
  localparam int S_HSCK = 2;
  localparam int S_DEC = 3;
  localparam int S_FR1 = 4;
  localparam int S_FR2 = 5;
  localparam int S_FR3 = 6;
  localparam int S_LK1 = 7;
  localparam int S_LK2 = 8;
  localparam int S_LKEN = 9;
  localparam int S_VDIV = 10;
  localparam int S_BIAS = 11;
  localparam int S_CMP1 = 12;
  localparam int S_CMP2 = 13;
  localparam int S_SSC0 = 14;
  localparam int SSC_LEN = 6;
  localparam int S_MODE = S_SSC0 + SSC_LEN;
  localparam int S_AUX1 = S_MODE + 1;
  localparam int S_AUX2 = S_MODE + 2;
  localparam int S_LANE0 = S_MODE + 3;
  localparam int GRP_LEN = 3;

  typedef enum logic [1:0] {RB_1G62, RB_2G70, RB_5G40, RB_8G10} rate_bkt_e;

  typedef struct packed {
    logic [7:0] hs_sel;
    logic [7:0] dec;
    logic [7:0] frac2;
    logic [7:0] frac3;
    logic [7:0] lock1;
    logic [7:0] lock2;
    logic [7:0] lock_en;
    logic [7:0] vco_div;
    logic [7:0] step1;
    logic [7:0] step2;
    logic [7:0] per1;
    logic [7:0] cmp1;
    logic [7:0] cmp2;
  } rate_set_t;

  function automatic rate_bkt_e snap_rate(input logic [31:0] scaled);
    if (scaled <= 32'(THR_LO)) return RB_1G62;
    else if (scaled <= 32'(THR_MID)) return RB_2G70;
    else if (scaled <= 32'(THR_HI)) return RB_5G40;
    else return RB_8G10;
  endfunction

  function automatic rate_set_t rate_params(input rate_bkt_e b);
    case (b)
      RB_1G62: return '{8'h05, 8'h69, 8'h80, 8'h07, 8'h6f, 8'h08, 8'h04,
                        8'h01, 8'h45, 8'h06, 8'h36, 8'hE2, 8'h18};
      RB_2G70: return '{8'h03, 8'h69, 8'h80, 8'h07, 8'h0f, 8'h0e, 8'h08,
                        8'h01, 8'h13, 8'h06, 8'h40, 8'hE2, 8'h18};
      RB_5G40: return '{8'h01, 8'h8c, 8'h00, 8'h0a, 8'h1f, 8'h1c, 8'h08,
                        8'h02, 8'h1a, 8'h08, 8'h40, 8'h2E, 8'h21};
      default: return '{8'h00, 8'h69, 8'h80, 8'h07, 8'h2f, 8'h2a, 8'h08,
                        8'h00, 8'h13, 8'h06, 8'h40, 8'hE2, 8'h18};
    endcase
  endfunction

  // divide ratio 6 -> 0, 2 -> 1, 4 -> 2
  function automatic logic [1:0] div_code(input rate_bkt_e b);
    case (b)
      RB_8G10: return 2'd0;
      RB_5G40: return 2'd2;
      default: return 2'd1;
    endcase
  endfunction
endpackage

// File: rtl/lrps_rate_snap.sv
module lrps_rate_snap
  import lrps_pkg::*;
#(
  parameter int RATE_W = 16
) (
  input  logic [RATE_W-1:0] rate_req,
  output rate_bkt_e         bkt,
  output logic              is_zero
);
  logic [31:0] scaled;

  assign scaled  = 32'(rate_req) * 32'd10;
  assign bkt     = snap_rate(scaled);
  assign is_zero = (rate_req == '0);
endmodule

// File: rtl/lrps_step_table.sv
module lrps_step_table
  import lrps_pkg::*;
#(
  parameter int NUM_PAIRS = 2,
  parameter int STEP_W = 5
) (
  input  logic [STEP_W-1:0] step,
  input  rate_bkt_e         bkt,
  input  logic [3:0]        lanes,
  input  logic [3:0]        orient,
  input  logic              bonding,
  input  logic              ssc,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] data,
  output logic              last,
  output logic [STEP_W-1:0] next_step
);
  localparam int S_FINAL = S_LANE0 + NUM_PAIRS * GRP_LEN;

  rate_set_t rs;
  logic flipped, four_lane;
  logic [NUM_PAIRS-1:0] pair_hit;
  logic [ADDR_W-1:0] pair_addr [NUM_PAIRS];
  logic [DATA_W-1:0] pair_data [NUM_PAIRS];

  assign rs        = rate_params(bkt);
  assign flipped   = (orient == 4'd2);
  assign four_lane = (lanes == 4'd4);

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    localparam int BASE = S_LANE0 + p * GRP_LEN;
    assign pair_hit[p]  = (step >= STEP_W'(BASE)) && (step < STEP_W'(BASE + GRP_LEN));
    assign pair_addr[p] = (step == STEP_W'(BASE))     ? ADDR_W'(8'h0C + p) :
                          (step == STEP_W'(BASE + 1)) ? ADDR_W'(8'h40 + 16 * p) :
                                                        ADDR_W'(8'h41 + 16 * p);
    assign pair_data[p] = (step == STEP_W'(BASE))     ? 8'h05 :
                          (step == STEP_W'(BASE + 1)) ? 8'h04 : 8'h0F;
  end

  always_comb begin
    addr = '0;
    data = '0;
    case (step)
      STEP_W'(S_CFG1): begin addr = 8'h04; data = 8'h0F; end
      STEP_W'(S_PWDN): begin
        addr = 8'h06;
        data = four_lane ? 8'h7d : (flipped ? 8'h6d : 8'h75);
      end
      STEP_W'(S_HSCK): begin addr = 8'h10; data = rs.hs_sel; end
      STEP_W'(S_DEC):  begin addr = 8'h11; data = rs.dec; end
      STEP_W'(S_FR1):  begin addr = 8'h12; data = 8'h00; end
      STEP_W'(S_FR2):  begin addr = 8'h13; data = rs.frac2; end
      STEP_W'(S_FR3):  begin addr = 8'h14; data = rs.frac3; end
      STEP_W'(S_LK1):  begin addr = 8'h15; data = rs.lock1; end
      STEP_W'(S_LK2):  begin addr = 8'h16; data = rs.lock2; end
      STEP_W'(S_LKEN): begin addr = 8'h17; data = rs.lock_en; end
      STEP_W'(S_VDIV): begin addr = 8'h08; data = rs.vco_div; end
      STEP_W'(S_BIAS): begin addr = 8'h20; data = bonding ? 8'h1f : 8'h1D; end
      STEP_W'(S_CMP1): begin addr = 8'h21; data = rs.cmp1; end
      STEP_W'(S_CMP2): begin addr = 8'h22; data = rs.cmp2; end
      STEP_W'(S_SSC0):     begin addr = 8'h30; data = 8'h01; end
      STEP_W'(S_SSC0 + 1): begin addr = 8'h31; data = 8'h00; end
      STEP_W'(S_SSC0 + 2): begin addr = 8'h32; data = rs.per1; end
      STEP_W'(S_SSC0 + 3): begin addr = 8'h33; data = 8'h01; end
      STEP_W'(S_SSC0 + 4): begin addr = 8'h34; data = rs.step1; end
      STEP_W'(S_SSC0 + 5): begin addr = 8'h35; data = rs.step2; end
      STEP_W'(S_MODE): begin addr = 8'h07; data = flipped ? 8'h4c : 8'h5c; end
      STEP_W'(S_AUX1): begin addr = 8'h0A; data = 8'h13; end
      STEP_W'(S_AUX2): begin addr = 8'h0B; data = 8'hA4; end
      STEP_W'(S_FINAL): begin addr = 8'h08; data = {6'd0, div_code(bkt)}; end
      default: begin
        for (int p = 0; p < NUM_PAIRS; p++) begin
          if (pair_hit[p]) begin
            addr = pair_addr[p];
            data = pair_data[p];
          end
        end
      end
    endcase
  end

  assign last      = (step == STEP_W'(S_FINAL));
  assign next_step = (step == STEP_W'(S_CMP2) && !ssc) ? STEP_W'(S_MODE) : step + 1'b1;
endmodule

// File: rtl/link_rate_phy_seq.sv
module link_rate_phy_seq
  import lrps_pkg::*;
#(
  parameter int RATE_W = 16,
  parameter int NUM_PAIRS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [RATE_W-1:0] rate_req,
  input  logic [7:0]        spare_cfg,
  input  logic              bonding_en,
  input  logic              ssc_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic              busy,
  output logic              done,
  output logic              err
);
  localparam int S_FINAL = S_LANE0 + NUM_PAIRS * GRP_LEN;
  localparam int STEP_W = $clog2(S_FINAL + 1);

  rate_bkt_e req_bkt, cfg_bkt;
  logic req_zero;
  logic [STEP_W-1:0] step, next_step;
  logic [3:0] cfg_lanes, cfg_orient;
  logic cfg_bond, cfg_ssc;
  logic last_step;

  // named events
  logic accept_start, reject_start, handshake, final_write;
  assign accept_start = !busy && start && !req_zero;
  assign reject_start = !busy && start && req_zero;
  assign handshake    = wr_valid && wr_ready;
  assign final_write  = handshake && last_step;

  lrps_rate_snap #(.RATE_W(RATE_W)) u_snap (
    .rate_req(rate_req), .bkt(req_bkt), .is_zero(req_zero)
  );

  lrps_step_table #(.NUM_PAIRS(NUM_PAIRS), .STEP_W(STEP_W)) u_tab (
    .step(step), .bkt(cfg_bkt), .lanes(cfg_lanes), .orient(cfg_orient),
    .bonding(cfg_bond), .ssc(cfg_ssc), .addr(wr_addr), .data(wr_data),
    .last(last_step), .next_step(next_step)
  );

  assign wr_valid = busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      done       <= 1'b0;
      err        <= 1'b0;
      step       <= '0;
      cfg_bkt    <= RB_1G62;
      cfg_lanes  <= '0;
      cfg_orient <= '0;
      cfg_bond   <= 1'b0;
      cfg_ssc    <= 1'b0;
    end else if (reject_start) begin
      err  <= 1'b1;
      done <= 1'b0;
    end else if (accept_start) begin
      busy       <= 1'b1;
      done       <= 1'b0;
      err        <= 1'b0;
      step       <= '0;
      cfg_bkt    <= req_bkt;
      cfg_lanes  <= spare_cfg[3:0];
      cfg_orient <= spare_cfg[7:4];
      cfg_bond   <= bonding_en;
      cfg_ssc    <= ssc_en;
    end else if (final_write) begin
      busy <= 1'b0;
      done <= 1'b1;
    end else if (handshake) begin
      step <= next_step;
    end
  end
endmodule

// File: rtl/lrps_checker.sv
module lrps_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] wr_addr,
  input logic [7:0] wr_data,
  input logic       wr_valid,
  input logic       wr_ready,
  input logic       busy,
  input logic       done,
  input logic       err,
  input logic       cfg_ssc
);
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

  p_valid_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid == busy);

  p_err_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !wr_valid && !done);

  p_done_idle_r13: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !wr_valid && !err);

  p_first_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> wr_addr == 8'h04 && wr_data == 8'h0F);

  p_no_ssc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !cfg_ssc |-> wr_addr[7:4] != 4'h3);

  p_end_div_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done && $past(wr_addr) == 8'h08);
endmodule

bind link_rate_phy_seq lrps_checker u_chk (
  .clk(clk), .rst_n(rst_n), .wr_addr(wr_addr), .wr_data(wr_data),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .busy(busy), .done(done),
  .err(err), .cfg_ssc(cfg_ssc)
);

// File: tb/link_rate_phy_seq_bench.sv
module link_rate_phy_seq_bench;
  logic clk = 0, rst_n = 0, start = 0;
  logic [15:0] rate_req = '0;
  logic [7:0] spare_cfg = '0;
  logic bonding_en = 0, ssc_en = 0, wr_ready = 0;
  logic [7:0] wr_addr, wr_data;
  logic wr_valid, busy, done, err;

  int errors = 0, checks = 0, cyc = 0, rmode = 0;
  logic [7:0] exp_a[$], exp_d[$], cap_a[$], cap_d[$];

  always #5 clk = ~clk;

  link_rate_phy_seq u_link_rate_phy_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .rate_req(rate_req),
    .spare_cfg(spare_cfg), .bonding_en(bonding_en), .ssc_en(ssc_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .busy(busy), .done(done), .err(err)
  );

  // ready pattern and capture of accepted writes, away from the active edge
  always @(negedge clk) begin
    cyc++;
    case (rmode)
      1: wr_ready = cyc[0];
      2: wr_ready = (cyc % 3 == 2);
      default: wr_ready = 1'b1;
    endcase
    if (wr_valid && wr_ready) begin
      cap_a.push_back(wr_addr);
      cap_d.push_back(wr_data);
    end
    if (cyc > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog: run hung, actual=%0d cycles expected<100000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  task automatic push(input logic [7:0] a, input logic [7:0] d);
    exp_a.push_back(a);
    exp_d.push_back(d);
  endtask

  // expected write list, restated from the requirements
  task automatic build(input int rate, input logic [7:0] sp, input bit bond, input bit ssc);
    int r10, b;
    bit flip, four;
    logic [7:0] hs, de, f2, f3, l1, l2, le, vd, s1, s2, pe, c1, c2;
    exp_a.delete(); exp_d.delete();
    r10 = rate * 10;
    b = (r10 <= 1620) ? 0 : (r10 <= 2700) ? 1 : (r10 <= 5400) ? 2 : 3;
    case (b)
      0: {hs,de,f2,f3,l1,l2,le,vd,s1,s2,pe,c1,c2} =
         {8'h05,8'h69,8'h80,8'h07,8'h6f,8'h08,8'h04,8'h01,8'h45,8'h06,8'h36,8'hE2,8'h18};
      1: {hs,de,f2,f3,l1,l2,le,vd,s1,s2,pe,c1,c2} =
         {8'h03,8'h69,8'h80,8'h07,8'h0f,8'h0e,8'h08,8'h01,8'h13,8'h06,8'h40,8'hE2,8'h18};
      2: {hs,de,f2,f3,l1,l2,le,vd,s1,s2,pe,c1,c2} =
         {8'h01,8'h8c,8'h00,8'h0a,8'h1f,8'h1c,8'h08,8'h02,8'h1a,8'h08,8'h40,8'h2E,8'h21};
      default: {hs,de,f2,f3,l1,l2,le,vd,s1,s2,pe,c1,c2} =
         {8'h00,8'h69,8'h80,8'h07,8'h2f,8'h2a,8'h08,8'h00,8'h13,8'h06,8'h40,8'hE2,8'h18};
    endcase
    flip = (sp[7:4] == 4'd2);
    four = (sp[3:0] == 4'd4);
    push(8'h04, 8'h0F);
    push(8'h06, four ? 8'h7d : flip ? 8'h6d : 8'h75);
    push(8'h10, hs); push(8'h11, de); push(8'h12, 8'h00); push(8'h13, f2);
    push(8'h14, f3); push(8'h15, l1); push(8'h16, l2); push(8'h17, le);
    push(8'h08, vd); push(8'h20, bond ? 8'h1f : 8'h1D);
    push(8'h21, c1); push(8'h22, c2);
    if (ssc) begin
      push(8'h30, 8'h01); push(8'h31, 8'h00); push(8'h32, pe);
      push(8'h33, 8'h01); push(8'h34, s1); push(8'h35, s2);
    end
    push(8'h07, flip ? 8'h4c : 8'h5c);
    push(8'h0A, 8'h13); push(8'h0B, 8'hA4);
    for (int p = 0; p < 2; p++) begin
      push(8'(8'h0C + p), 8'h05);
      push(8'(8'h40 + 16 * p), 8'h04);
      push(8'(8'h41 + 16 * p), 8'h0F);
    end
    push(8'h08, (b == 3) ? 8'd0 : (b == 2) ? 8'd2 : 8'd1);
  endtask

  task automatic t_run(input int rate, input logic [7:0] sp, input bit bond, input bit ssc,
                       input int rm, input bit disturb, input string tag);
    int n;
    build(rate, sp, bond, ssc);
    cap_a.delete(); cap_d.delete();
    @(negedge clk);
    rmode = rm;
    rate_req = 16'(rate); spare_cfg = sp; bonding_en = bond; ssc_en = ssc;
    start = 1;
    @(negedge clk);
    start = 0;
    chk(busy && !done && !err, {"R13 start ", tag}, {busy, done, err}, 3'b100);
    n = 0;
    while (!done && n < 500) begin
      @(negedge clk);
      n++;
      if (disturb && n == 3) begin
        rate_req = 16'd800; spare_cfg = 8'h24; bonding_en = !bond; ssc_en = !ssc;
        start = 1;
      end else start = 0;
    end
    start = 0;
    chk(done && !busy, {"R13 done ", tag}, {done, busy}, 2'b10);
    chk(cap_a.size() == exp_a.size(), {"R5 R11 count ", tag}, cap_a.size(), exp_a.size());
    for (int i = 0; i < exp_a.size() && i < cap_a.size(); i++) begin
      chk(cap_a[i] == exp_a[i], {"R10 addr ", tag}, cap_a[i], exp_a[i]);
      chk(cap_d[i] == exp_d[i], {"R1 R3 data ", tag}, cap_d[i], exp_d[i]);
    end
  endtask

  task automatic t_zero();
    cap_a.delete(); cap_d.delete();
    @(negedge clk);
    rate_req = '0; start = 1;
    @(negedge clk);
    start = 0;
    chk(err && !done && !busy && !wr_valid, "R2 zero rate flags", {err, done, busy}, 3'b100);
    repeat (5) @(negedge clk);
    chk(cap_a.size() == 0, "R2 zero rate writes", cap_a.size(), 0);
  endtask

  task automatic t_reset();
    chk(!busy && !done && !err && !wr_valid, "R13 reset state",
        {busy, done, err, wr_valid}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    // R1 R3 R4 R5 R9 R10: 1.62 bucket, four lanes, ssc on
    t_run(162, 8'h14, 0, 1, 0, 0, "R4 four lane");
    // R1 boundary above 1.62, R6 R8 flipped two lanes, R7 bonding, ssc off
    t_run(163, 8'h22, 1, 0, 1, 0, "R6 R7 R8 flipped");
    // R1 exact 2.7, normal orientation
    t_run(270, 8'h12, 0, 1, 2, 0, "R1 exact 2.7");
    t_zero();
    // R2 cleared by a good request, R9 5.4 code
    t_run(540, 8'h21, 1, 1, 0, 0, "R9 5.4");
    chk(!err, "R2 err cleared", err, 0);
    t_run(541, 8'h04, 0, 0, 1, 0, "R9 8.1");
    t_run(1, 8'h31, 0, 1, 0, 0, "R1 low");
    t_run(65535, 8'h12, 1, 0, 2, 0, "R1 max");
    // R12: inputs and a second start during the run have no effect
    t_run(162, 8'h12, 0, 1, 1, 1, "R12 disturb");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule